// File: doc/BRIEF.md
# Dual-CPU Address Decoder with Address-Bit Control Latches

This block sits on the address buses of two 8-bit processors in a three-processor video system. One is the main CPU and the other the sound CPU. From the upper address bits of each bus, the read/write line and a valid-access qualifier, it drives one-hot chip selects. These cover the tilemap RAM, three work RAMs, the RAM shared with the sound CPU, the I/O chips, the starfield control port and the program ROMs. The low address bits and the data bus go straight to those devices, so the decoder only takes main-CPU bits A15..A11 and sound-CPU bits A15..A13.

A handful of control flags are set by the address of a write and not by its data. The write's data value plays no part. A write into a control window copies one address line into a flag: A11 for the main CPU, A13 for the sound CPU. The flags are:
- the main and sound interrupt enables;
- the run flag that releases the other processors from reset and turns sound on;
- the run flag for the I/O chips.

Each interrupt request is raised by a vertical-blank pulse while its enable is set. It is dropped by writing the enable to zero.

A watchdog counts vertical-blank pulses. Certain decoded accesses clear it. If it reaches the limit it emits a one-cycle main reset pulse.

Top module: `dual_cpu_decode`

## Requirements
- R1: With the main qualifier high, A15..A11 = 00000 selects the tilemap RAM (main_sel bit 0). A15..A11 = 00001, 00010 and 00011 select work RAMs 0, 1 and 2 (main_sel bits 1, 2 and 3). This holds for reads and writes.
- R2: A main access with A15..A11 = 01100 selects the shared sound RAM (bit 4), and 01101 selects the I/O chips (bit 5). In both cases A10 has no effect.
- R3: A main read selects ROM 0 (bit 7) for 0x8000–0xBFFF, ROM 1 (bit 8) for 0xC000–0xDFFF and ROM 2 (bit 9) for 0xE000–0xFFFF. A main write in 0x8000–0xFFFF never selects a ROM.
- R4: A main write with A15..A11 = 10100 asserts the starfield strobe (bit 6). A read at the same address selects ROM 0 instead.
- R5: main_sel and snd_sel are all zero while the matching qualifier is low. They are also all zero for an address that maps nothing: main 0x2000–0x5FFF, main 0x7000–0x7FFF, main writes in 0x8000–0x9FFF and 0xA800–0xFFFF, and sound 0x2000–0xBFFF. At most one bit is ever set.
- R6: A main write in 0x7000–0x7FFF loads the main interrupt enable from A11. 0x70xx clears it and 0x78xx sets it. The new value is in effect from the next clock.
- R7: A main write in 0x8000–0x8FFF loads the peer run flag from A11. A main write in 0x9000–0x9FFF loads the I/O run flag from A11. peer_reset and io_reset are the inverse of their flags, and sound_on equals the peer flag. After reset both flags are 0, so peer_reset = 1, io_reset = 1 and sound_on = 0.
- R8: A sound access with A15..A13 = 000 selects the shared RAM (snd_sel bit 0) for reads and writes. A sound read in 0xC000–0xFFFF selects the sound ROM (snd_sel bit 1).
- R9: A sound write in 0x4000–0x7FFF loads the sound interrupt enable from A13. 0x4xxx clears it and 0x6xxx sets it.
- R10: An interrupt request rises on the clock after a vblank pulse if its enable is 1 at that pulse. It stays high until its enable is written to 0, and falls on the clock that takes that write. With its enable at 0 it never rises.
- R11: After WDOG_FRAMES vblank pulses with no kick, main_reset is high for exactly one cycle, on the clock after the last pulse. The count then restarts.
- R12: A main read in 0x7800–0x7FFF and any sound access in 0x2000–0x3FFF restart the watchdog count. A main read in 0x7000–0x77FF and a main write to 0x78xx do not. A kick in the same cycle as a vblank pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| main_valid | input | 1 | Main CPU valid-access qualifier |
| main_wr | input | 1 | Main CPU write (1) / read (0) |
| main_addr_hi | input | 5 | Main CPU address bits A15..A11 |
| snd_valid | input | 1 | Sound CPU valid-access qualifier |
| snd_wr | input | 1 | Sound CPU write (1) / read (0) |
| snd_addr_hi | input | 3 | Sound CPU address bits A15..A13 |
| main_sel | output | 10 | Main one-hot selects: 0 tile, 1-3 work, 4 shared RAM, 5 I/O, 6 starfield, 7-9 ROM 0-2 |
| snd_sel | output | 2 | Sound one-hot selects: 0 shared RAM, 1 ROM |
| main_irq | output | 1 | Main CPU interrupt request |
| snd_irq | output | 1 | Sound CPU interrupt request |
| peer_reset | output | 1 | Holds the sub and sound CPUs in reset when 1 |
| sound_on | output | 1 | Sound output enable |
| io_reset | output | 1 | Holds the I/O chips in reset when 1 |
| main_reset | output | 1 | One-cycle watchdog reset pulse for the main CPU |

## Verification
The chip selects are combinational. The bench drives each access just after a falling edge and reads main_sel or snd_sel 2 ns later, in the same cycle. The latches, both interrupt requests and the watchdog pulse pass through one register each. So each access or vblank pulse is held across exactly one rising edge, and those outputs are read at the next falling edge. The watchdog pulse is also read one falling edge later to confirm it has already gone low.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int MAIN_HI_W  = 5;  // main CPU A15..A11
    localparam int SND_HI_W   = 3;  // sound CPU A15..A13
    localparam int MAIN_SEL_N = 10;
    localparam int SND_SEL_N  = 2;

    // main select bit positions
    localparam int MS_TILE  = 0;
    localparam int MS_WORK0 = 1;
    localparam int MS_WORK1 = 2;
    localparam int MS_WORK2 = 3;
    localparam int MS_SHRAM = 4;
    localparam int MS_IO    = 5;
    localparam int MS_STAR  = 6;
    localparam int MS_ROM0  = 7;
    localparam int MS_ROM1  = 8;
    localparam int MS_ROM2  = 9;

    // sound select bit positions
    localparam int SS_SHRAM = 0;
    localparam int SS_ROM   = 1;

    typedef struct packed {
        logic main_ie;
        logic snd_ie;
        logic peer_run;
        logic io_run;
        logic main_irq;
        logic snd_irq;
    } ctrl_t;

endpackage

// File: rtl/dcd_main_map.sv
module dcd_main_map
    import dcd_pkg::*;
(
    input  logic                  valid,
    input  logic                  wr,
    input  logic [MAIN_HI_W-1:0]  a_hi,
    output logic [MAIN_SEL_N-1:0] sel,
    output logic                  ie_wr,
    output logic                  peer_wr,
    output logic                  io_wr,
    output logic                  kick,
    output logic                  latch_bit
);

    // a_hi[0] is A11, the data bit of every main control latch
    assign latch_bit = a_hi[0];

    always_comb begin
        sel     = '0;
        ie_wr   = 1'b0;
        peer_wr = 1'b0;
        io_wr   = 1'b0;
        kick    = 1'b0;
        if (valid) begin
            casez (a_hi)
                5'b00000: sel[MS_TILE]  = 1'b1;
                5'b00001: sel[MS_WORK0] = 1'b1;
                5'b00010: sel[MS_WORK1] = 1'b1;
                5'b00011: sel[MS_WORK2] = 1'b1;
                5'b01100: sel[MS_SHRAM] = 1'b1;
                5'b01101: sel[MS_IO]    = 1'b1;
                5'b0111?: begin
                    if (wr)          ie_wr = 1'b1;
                    else if (a_hi[0]) kick = 1'b1;
                end
                5'b1000?: begin
                    if (wr) peer_wr = 1'b1;
                    else    sel[MS_ROM0] = 1'b1;
                end
                5'b1001?: begin
                    if (wr) io_wr = 1'b1;
                    else    sel[MS_ROM0] = 1'b1;
                end
                5'b10100: begin
                    if (wr) sel[MS_STAR] = 1'b1;
                    else    sel[MS_ROM0] = 1'b1;
                end
                5'b10101, 5'b1011?: begin
                    if (!wr) sel[MS_ROM0] = 1'b1;
                end
                5'b110??: begin
                    if (!wr) sel[MS_ROM1] = 1'b1;
                end
                5'b111??: begin
                    if (!wr) sel[MS_ROM2] = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcd_snd_map.sv
module dcd_snd_map
    import dcd_pkg::*;
(
    input  logic                 valid,
    input  logic                 wr,
    input  logic [SND_HI_W-1:0]  a_hi,
    output logic [SND_SEL_N-1:0] sel,
    output logic                 ie_wr,
    output logic                 kick,
    output logic                 latch_bit
);

    // a_hi[0] is A13, the data bit of the sound interrupt enable
    assign latch_bit = a_hi[0];

    always_comb begin
        sel   = '0;
        ie_wr = 1'b0;
        kick  = 1'b0;
        if (valid) begin
            casez (a_hi)
                3'b000: sel[SS_SHRAM] = 1'b1;
                3'b001: kick = 1'b1;
                3'b01?: ie_wr = wr;
                3'b11?: sel[SS_ROM] = ~wr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
    import dcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vblank,
    input  logic  m_ie_wr,
    input  logic  m_peer_wr,
    input  logic  m_io_wr,
    input  logic  m_bit,
    input  logic  s_ie_wr,
    input  logic  s_bit,
    output ctrl_t ctrl
);

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (m_ie_wr)   st_d.main_ie  = m_bit;
        if (m_peer_wr) st_d.peer_run = m_bit;
        if (m_io_wr)   st_d.io_run   = m_bit;
        if (s_ie_wr)   st_d.snd_ie   = s_bit;
        // request follows the enable in force after this cycle's write
        st_d.main_irq = st_d.main_ie & (st_q.main_irq | vblank);
        st_d.snd_irq  = st_d.snd_ie  & (st_q.snd_irq  | vblank);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q;

endmodule

// File: rtl/dcd_wdog.sv
module dcd_wdog #(
    parameter int WDOG_FRAMES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    input  logic kick,
    output logic fire
);

    localparam int CW = $clog2(WDOG_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_FRAMES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d      = wd_q;
        wd_d.fire = 1'b0;
        if (kick) begin
            wd_d.cnt = '0;
        end else if (vblank) begin
            if (wd_q.cnt == LAST) begin
                wd_d.cnt  = '0;
                wd_d.fire = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign fire = wd_q.fire;

endmodule

// File: rtl/dual_cpu_decode.sv
module dual_cpu_decode
    import dcd_pkg::*;
#(
    parameter int WDOG_FRAMES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vblank,
    input  logic                  main_valid,
    input  logic                  main_wr,
    input  logic [MAIN_HI_W-1:0]  main_addr_hi,
    input  logic                  snd_valid,
    input  logic                  snd_wr,
    input  logic [SND_HI_W-1:0]   snd_addr_hi,
    output logic [MAIN_SEL_N-1:0] main_sel,
    output logic [SND_SEL_N-1:0]  snd_sel,
    output logic                  main_irq,
    output logic                  snd_irq,
    output logic                  peer_reset,
    output logic                  sound_on,
    output logic                  io_reset,
    output logic                  main_reset
);

    logic  m_ie_wr, m_peer_wr, m_io_wr, m_kick, m_bit;
    logic  s_ie_wr, s_kick, s_bit;
    ctrl_t ctrl;

    dcd_main_map u_main (
        .valid     (main_valid),
        .wr        (main_wr),
        .a_hi      (main_addr_hi),
        .sel       (main_sel),
        .ie_wr     (m_ie_wr),
        .peer_wr   (m_peer_wr),
        .io_wr     (m_io_wr),
        .kick      (m_kick),
        .latch_bit (m_bit)
    );

    dcd_snd_map u_snd (
        .valid     (snd_valid),
        .wr        (snd_wr),
        .a_hi      (snd_addr_hi),
        .sel       (snd_sel),
        .ie_wr     (s_ie_wr),
        .kick      (s_kick),
        .latch_bit (s_bit)
    );

    dcd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .m_ie_wr   (m_ie_wr),
        .m_peer_wr (m_peer_wr),
        .m_io_wr   (m_io_wr),
        .m_bit     (m_bit),
        .s_ie_wr   (s_ie_wr),
        .s_bit     (s_bit),
        .ctrl      (ctrl)
    );

    dcd_wdog #(.WDOG_FRAMES(WDOG_FRAMES)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .vblank (vblank),
        .kick   (m_kick | s_kick),
        .fire   (main_reset)
    );

    assign main_irq   = ctrl.main_irq;
    assign snd_irq    = ctrl.snd_irq;
    assign peer_reset = ~ctrl.peer_run;
    assign sound_on   = ctrl.peer_run;
    assign io_reset   = ~ctrl.io_run;

endmodule

// File: rtl/dual_cpu_decode_chk.sv
module dual_cpu_decode_chk
    import dcd_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  vblank,
    input logic                  main_valid,
    input logic                  main_wr,
    input logic [MAIN_HI_W-1:0]  main_addr_hi,
    input logic                  snd_valid,
    input logic                  snd_wr,
    input logic [SND_HI_W-1:0]   snd_addr_hi,
    input logic [MAIN_SEL_N-1:0] main_sel,
    input logic [SND_SEL_N-1:0]  snd_sel,
    input logic                  main_irq,
    input logic                  snd_irq,
    input logic                  peer_reset,
    input logic                  sound_on,
    input logic                  io_reset,
    input logic                  main_reset
);

    p_onehot_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(main_sel) && $onehot0(snd_sel));

    p_idle_no_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_valid |-> main_sel == '0) and (!snd_valid |-> snd_sel == '0));

    p_snd_rom_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && !snd_wr && snd_addr_hi[2:1] == 2'b11) |-> snd_sel == 2'b10);

    p_ie_clear_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (main_valid && main_wr && main_addr_hi == 5'b01110) |=> !main_irq);

    p_irq_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (main_irq && !(main_valid && main_wr && main_addr_hi[4:1] == 4'b0111))
        |=> main_irq);

    p_peer_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_valid && main_wr && main_addr_hi[4:1] == 4'b1000)
        |=> (peer_reset != $past(main_addr_hi[0])) && (sound_on == $past(main_addr_hi[0])));

    p_io_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (main_valid && main_wr && main_addr_hi[4:1] == 4'b1001)
        |=> io_reset != $past(main_addr_hi[0]));

    p_snd_ie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_wr && snd_addr_hi == 3'b010) |=> !snd_irq);

    p_wdog_on_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        main_reset |-> $past(vblank));

    p_kick_blocks_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_addr_hi == 3'b001) |=> !main_reset);

endmodule

bind dual_cpu_decode dual_cpu_decode_chk u_chk (.*);

// File: tb/dual_cpu_decode_tb_top.sv
module dual_cpu_decode_tb_top;

    localparam int WD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vblank = 1'b0;
    logic       main_valid = 1'b0;
    logic       main_wr = 1'b0;
    logic [4:0] main_addr_hi = '0;
    logic       snd_valid = 1'b0;
    logic       snd_wr = 1'b0;
    logic [2:0] snd_addr_hi = '0;
    logic [9:0] main_sel;
    logic [1:0] snd_sel;
    logic       main_irq, snd_irq, peer_reset, sound_on, io_reset, main_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_cpu_decode #(.WDOG_FRAMES(WD)) dut_i (
        .clk(clk), .rst_n(rst_n), .vblank(vblank),
        .main_valid(main_valid), .main_wr(main_wr), .main_addr_hi(main_addr_hi),
        .snd_valid(snd_valid), .snd_wr(snd_wr), .snd_addr_hi(snd_addr_hi),
        .main_sel(main_sel), .snd_sel(snd_sel),
        .main_irq(main_irq), .snd_irq(snd_irq),
        .peer_reset(peer_reset), .sound_on(sound_on),
        .io_reset(io_reset), .main_reset(main_reset)
    );

    // {valid, wr, addr[15:0], expected main_sel[9:0]}
    localparam int NM = 20;
    localparam logic [27:0] MAIN_VEC [NM] = '{
        {2'b10, 16'h0123, 10'h001},   // R1 tile
        {2'b11, 16'h0800, 10'h002},   // R1 work0
        {2'b10, 16'h1400, 10'h004},   // R1 work1
        {2'b11, 16'h1FFF, 10'h008},   // R1 work2
        {2'b10, 16'h6000, 10'h010},   // R2 shared
        {2'b11, 16'h6400, 10'h010},   // R2 mirror via A10
        {2'b11, 16'h6820, 10'h020},   // R2 io
        {2'b10, 16'h6C00, 10'h020},   // R2 io mirror
        {2'b10, 16'h2000, 10'h000},   // R5 hole
        {2'b11, 16'h5FFF, 10'h000},   // R5 hole
        {2'b10, 16'h7800, 10'h000},   // R5 watchdog window
        {2'b10, 16'h8000, 10'h080},   // R3 rom0
        {2'b11, 16'hA002, 10'h040},   // R4 star
        {2'b10, 16'hA001, 10'h080},   // R4 read -> rom0
        {2'b10, 16'hB000, 10'h080},   // R3 rom0 upper
        {2'b10, 16'hC000, 10'h100},   // R3 rom1
        {2'b10, 16'hE123, 10'h200},   // R3 rom2
        {2'b11, 16'hF000, 10'h000},   // R3 write to rom
        {2'b11, 16'hB800, 10'h000},   // R5 write no target
        {2'b00, 16'h0800, 10'h000}    // R5 qualifier low
    };

    // {valid, wr, addr[15:0], expected snd_sel[1:0]}
    localparam int NS = 8;
    localparam logic [19:0] SND_VEC [NS] = '{
        {2'b10, 16'h0000, 2'b01},     // R8 shared read
        {2'b11, 16'h1FFF, 2'b01},     // R8 shared write
        {2'b10, 16'hC000, 2'b10},     // R8 rom
        {2'b10, 16'hFFFF, 2'b10},     // R8 rom top
        {2'b11, 16'hC000, 2'b00},     // R8 write to rom
        {2'b10, 16'h8000, 2'b00},     // R5 hole
        {2'b10, 16'h3000, 2'b00},     // R5 watchdog window
        {2'b00, 16'h0000, 2'b00}      // R5 qualifier low
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // holds one access across one rising edge; sel sampled in that cycle
    task automatic main_access(input logic wr, input logic [15:0] addr, output logic [9:0] s);
        @(negedge clk);
        main_valid = 1'b1; main_wr = wr; main_addr_hi = addr[15:11];
        #2 s = main_sel;
        @(negedge clk);
        main_valid = 1'b0; main_wr = 1'b0;
    endtask

    task automatic snd_access(input logic wr, input logic [15:0] addr);
        @(negedge clk);
        snd_valid = 1'b1; snd_wr = wr; snd_addr_hi = addr[15:13];
        @(negedge clk);
        snd_valid = 1'b0; snd_wr = 1'b0;
    endtask

    task automatic vbl();
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0;
    endtask

    initial begin
        logic [9:0] s;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7 reset peer_reset", 32'(peer_reset), 1);
        chk("R7 reset io_reset", 32'(io_reset), 1);
        chk("R7 reset sound_on", 32'(sound_on), 0);
        chk("R10 reset main_irq", 32'(main_irq), 0);
        chk("R11 reset main_reset", 32'(main_reset), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NM; i++) begin
            @(negedge clk);
            main_valid = MAIN_VEC[i][27]; main_wr = MAIN_VEC[i][26];
            main_addr_hi = MAIN_VEC[i][25:21];
            #2 chk($sformatf("R1-map main vec %0d", i), 32'(main_sel), 32'(MAIN_VEC[i][9:0]));
        end
        @(negedge clk); main_valid = 1'b0; main_wr = 1'b0;
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            snd_valid = SND_VEC[i][19]; snd_wr = SND_VEC[i][18];
            snd_addr_hi = SND_VEC[i][17:15];
            #2 chk($sformatf("R8 snd vec %0d", i), 32'(snd_sel), 32'(SND_VEC[i][1:0]));
        end
        @(negedge clk); snd_valid = 1'b0; snd_wr = 1'b0;

        // R7 run latches from A11
        main_access(1'b1, 16'h8800, s);
        chk("R5 latch write no sel", 32'(s), 0);
        chk("R7 peer released", 32'(peer_reset), 0);
        chk("R7 sound on", 32'(sound_on), 1);
        chk("R7 io untouched", 32'(io_reset), 1);
        main_access(1'b1, 16'h9800, s);
        chk("R7 io released", 32'(io_reset), 0);
        main_access(1'b1, 16'h8000, s);
        chk("R7 peer held again", 32'(peer_reset), 1);
        chk("R7 io kept", 32'(io_reset), 0);

        // R10 / R6 main interrupt
        vbl();
        chk("R10 no irq while disabled", 32'(main_irq), 0);
        main_access(1'b1, 16'h7800, s);
        chk("R6 enable alone no irq", 32'(main_irq), 0);
        vbl();
        chk("R10 irq after vblank", 32'(main_irq), 1);
        chk("R9 snd irq stays low", 32'(snd_irq), 0);
        @(negedge clk);
        chk("R10 irq held", 32'(main_irq), 1);
        main_access(1'b1, 16'h7000, s);
        chk("R6 clear drops irq", 32'(main_irq), 0);
        vbl();
        chk("R6 cleared enable blocks irq", 32'(main_irq), 0);

        // R9 sound interrupt
        snd_access(1'b1, 16'h6000);
        vbl();
        chk("R9 snd irq after vblank", 32'(snd_irq), 1);
        chk("R9 main irq unaffected", 32'(main_irq), 0);
        snd_access(1'b1, 16'h4000);
        chk("R9 snd clear", 32'(snd_irq), 0);

        // R11 watchdog expiry
        main_access(1'b0, 16'h7800, s);
        for (int k = 0; k < WD - 1; k++) begin
            vbl();
            chk("R11 no early reset", 32'(main_reset), 0);
        end
        vbl();
        chk("R11 reset on last frame", 32'(main_reset), 1);
        @(negedge clk);
        chk("R11 reset single cycle", 32'(main_reset), 0);

        // R12 sound kick restarts count
        for (int k = 0; k < WD - 1; k++) vbl();
        snd_access(1'b1, 16'h3000);
        for (int k = 0; k < WD - 1; k++) vbl();
        chk("R12 sound kick restarts", 32'(main_reset), 0);
        vbl();
        chk("R12 fires after kick", 32'(main_reset), 1);

        // R12 read 0x7000 and write 0x7800 do not kick
        main_access(1'b0, 16'h7800, s);
        for (int k = 0; k < WD - 1; k++) vbl();
        main_access(1'b0, 16'h7000, s);
        main_access(1'b1, 16'h7800, s);
        vbl();
        chk("R12 non-kicking accesses", 32'(main_reset), 1);
        main_access(1'b1, 16'h7000, s);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule